// File: doc/BRIEF.md
# Shared-Datapath SIMON 32/64 Cipher Core

This block runs the SIMON 32/64 block cipher in either direction through one fully unrolled chain of Feistel rounds. The whole chain is combinational. One request finishes in the clock edge that accepts it, and the result register holds the answer until the next request. A direction flag picks one of two keys. The first is the ordinary 64-bit cipher key, which is expanded forward. The second is a 64-bit decryption key made of the four final round subkeys, which is expanded backwards. In both directions the key expansion runs alongside the rounds, so no stored subkey table is needed.

Decryption uses the same round logic as encryption. The two input halves are exchanged before the first round. The subkeys are applied from last to first. The two halves are exchanged back after the last round, so decrypting a ciphertext returns the original plaintext. The block is meant to sit inside a memory-path encryption unit. That unit supplies a key and a direction on each access, and holds the keys itself.

Top module: `simon_shared_core`

## Requirements
- R1: While `rst_n` is low, and after release until the first request, `res_valid` is 0 and `res_block` is 0.
- R2: `res_valid` is 1 in the cycle after an edge that samples `req_valid` high, and 0 after an edge that samples it low.
- R3: With `req_decrypt`=0, key 0x1918111009080100 and block 0x65656877 give 0xC69BE9BB.
- R4: With `req_decrypt`=1, a decryption key packed as {k31,k30,k29,k28} (k31 in bits 63:48) and block 0xC69BE9BB give 0x65656877. Here kN is subkey N of the key in R3.
- R5: Encryption matches SIMON 32/64 for any key and block. Layout: block bits 31:16 are the left word and 15:0 the right word. Key bits 63:48 are k3 and 15:0 are k0. The schedule uses constant 0xFFFC and sequence z0.
- R6: For any key and block, decrypting the encryption result with the packed last-four-subkey key returns the block.
- R7: When encrypting, `dec_key` has no effect on `res_block`. When decrypting, `enc_key` has no effect.
- R8: While `req_valid` is low, `res_block` keeps its last value, whatever the other inputs do.
- R9: Requests on consecutive cycles, in alternating directions, each give their own correct result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_decrypt | input | 1 | 1 selects decryption, 0 selects encryption |
| req_block | input | 32 | Plaintext or ciphertext word |
| enc_key | input | 64 | Cipher key {k3,k2,k1,k0} |
| dec_key | input | 64 | Last four subkeys {k31,k30,k29,k28} |
| res_valid | output | 1 | `res_block` holds a fresh result |
| res_block | output | 32 | Registered cipher output |

## Verification
The assertions assume that `req_valid` is never unknown once reset is released. The result register only loads when `req_valid` is 1, so an unknown flag would make the hold and known-output checks meaningless. They also assume that when `req_valid` is high, the block and the selected key carry defined values. The bench drives every input at the falling edge and starts from defined values at time zero. It never leaves a key or block undriven, including while it deliberately changes the unused key or idle inputs to show that they are ignored.

// File: rtl/simon_pkg.sv
package simon_pkg;

    localparam int SIMON_WORD = 16;
    localparam int KEY_WORDS  = 4;
    localparam int SEQ_LEN    = 62;

    typedef logic [SIMON_WORD-1:0] word_t;

    // Schedule constant: all ones except the two low bits.
    localparam word_t SCHED_CONST = 16'hFFFC;

    // z0 sequence, element j at index j.
    localparam logic [0:SEQ_LEN-1] Z0_SEQ =
        62'b11111010_00100101_01100001_11001101_11110100_01001010_11000011_100110;

    typedef struct packed {
        logic                      valid;
        logic [2*SIMON_WORD-1:0]   data;
    } res_reg_t;

    function automatic word_t rotl(input word_t x, input int n);
        rotl = (x << n) | (x >> (SIMON_WORD - n));
    endfunction

    function automatic word_t rotr(input word_t x, input int n);
        rotr = (x >> n) | (x << (SIMON_WORD - n));
    endfunction

    function automatic word_t mix_f(input word_t x);
        mix_f = (rotl(x, 1) & rotl(x, 8)) ^ rotl(x, 2);
    endfunction

endpackage

// File: rtl/simon_round.sv
module simon_round
    import simon_pkg::*;
(
    input  word_t left_i,
    input  word_t right_i,
    input  word_t rkey_i,
    output word_t left_o,
    output word_t right_o
);

    always_comb begin
        left_o  = right_i ^ mix_f(left_i) ^ rkey_i;
        right_o = left_i;
    end

endmodule

// File: rtl/simon_key_step.sv
module simon_key_step
    import simon_pkg::*;
#(
    parameter bit Z_FWD = 1'b0,
    parameter bit Z_REV = 1'b0
) (
    input  logic                            dec_i,
    input  logic [KEY_WORDS*SIMON_WORD-1:0] window_i,
    output word_t                           subkey_o,
    output logic [KEY_WORDS*SIMON_WORD-1:0] window_o
);

    word_t w0, w1, w2, w3;
    word_t base_w, far_w, near_w, mix_w, fresh_w;

    always_comb begin
        w0 = window_i[0*SIMON_WORD +: SIMON_WORD];
        w1 = window_i[1*SIMON_WORD +: SIMON_WORD];
        w2 = window_i[2*SIMON_WORD +: SIMON_WORD];
        w3 = window_i[3*SIMON_WORD +: SIMON_WORD];

        // Forward: window {k[r+3],k[r+2],k[r+1],k[r]} -> new k[r+4].
        // Reverse: window {k[j+4],k[j+3],k[j+2],k[j+1]} -> recovered k[j].
        base_w = dec_i ? w3 : w0;
        far_w  = dec_i ? w2 : w3;
        near_w = dec_i ? w0 : w1;

        mix_w   = rotr(far_w, 3) ^ near_w;
        fresh_w = base_w ^ SCHED_CONST ^ word_t'(dec_i ? Z_REV : Z_FWD)
                  ^ mix_w ^ rotr(mix_w, 1);

        subkey_o = dec_i ? w3 : w0;
        window_o = dec_i ? {w2, w1, w0, fresh_w} : {fresh_w, w3, w2, w1};
    end

endmodule

// File: rtl/simon_shared_core.sv
module simon_shared_core
    import simon_pkg::*;
#(
    parameter int ROUNDS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_decrypt,
    input  logic [2*SIMON_WORD-1:0]       req_block,
    input  logic [KEY_WORDS*SIMON_WORD-1:0] enc_key,
    input  logic [KEY_WORDS*SIMON_WORD-1:0] dec_key,
    output logic                          res_valid,
    output logic [2*SIMON_WORD-1:0]       res_block
);

    localparam int BLOCK_W      = 2 * SIMON_WORD;
    localparam int KEY_W        = KEY_WORDS * SIMON_WORD;
    localparam int EXPAND_STEPS = ROUNDS - KEY_WORDS;

    word_t            lft [0:ROUNDS];
    word_t            rgt [0:ROUNDS];
    word_t            rkey [0:ROUNDS-1];
    logic [KEY_W-1:0] win [0:ROUNDS-1];
    logic [BLOCK_W-1:0] cipher_out;

    res_reg_t res_d, res_q;

    // Entry multiplexers: direction picks key seed and half order.
    assign win[0] = req_decrypt ? dec_key : enc_key;
    assign lft[0] = req_decrypt ? req_block[SIMON_WORD-1:0]       : req_block[BLOCK_W-1:SIMON_WORD];
    assign rgt[0] = req_decrypt ? req_block[BLOCK_W-1:SIMON_WORD] : req_block[SIMON_WORD-1:0];

    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
        if (r < ROUNDS - 1) begin : g_step
            localparam bit ZF = (r < EXPAND_STEPS) ? Z0_SEQ[r % SEQ_LEN] : 1'b0;
            localparam bit ZR = (r < EXPAND_STEPS) ? Z0_SEQ[(EXPAND_STEPS-1-r) % SEQ_LEN] : 1'b0;
            simon_key_step #(
                .Z_FWD (ZF),
                .Z_REV (ZR)
            ) key_step_i (
                .dec_i    (req_decrypt),
                .window_i (win[r]),
                .subkey_o (rkey[r]),
                .window_o (win[r+1])
            );
        end else begin : g_last
            assign rkey[r] = req_decrypt ? win[r][KEY_W-1 -: SIMON_WORD]
                                         : win[r][SIMON_WORD-1:0];
        end

        simon_round round_i (
            .left_i  (lft[r]),
            .right_i (rgt[r]),
            .rkey_i  (rkey[r]),
            .left_o  (lft[r+1]),
            .right_o (rgt[r+1])
        );
    end

    // Exit multiplexer: undo the half exchange after decryption.
    assign cipher_out = req_decrypt ? {rgt[ROUNDS], lft[ROUNDS]}
                                    : {lft[ROUNDS], rgt[ROUNDS]};

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.data = cipher_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_block = res_q.data;

endmodule

// File: rtl/simon_shared_core_chk.sv
module simon_shared_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        res_valid,
    input logic [31:0] res_block
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!res_valid && res_block == 32'h0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res_block));

    // R5
    known_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$isunknown(res_block));

endmodule

bind simon_shared_core simon_shared_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .res_valid (res_valid),
    .res_block (res_block)
);

// File: tb/simon_shared_core_tb_top.sv
module simon_shared_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_decrypt = 1'b0;
    logic [31:0] req_block = 32'h0;
    logic [63:0] enc_key = 64'h0;
    logic [63:0] dec_key = 64'h0;
    logic        res_valid;
    logic [31:0] res_block;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    simon_shared_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_decrypt (req_decrypt),
        .req_block   (req_block),
        .enc_key     (enc_key),
        .dec_key     (dec_key),
        .res_valid   (res_valid),
        .res_block   (res_block)
    );

    // ---------------- reference model ----------------
    localparam logic [61:0] TB_Z = 62'b11111010001001010110000111001101111101000100101011000011100110;

    function automatic logic [15:0] tb_rot(input logic [15:0] v, input int left);
        logic [31:0] dbl;
        dbl = {v, v};
        tb_rot = dbl[31-left -: 16];
    endfunction

    function automatic logic [15:0] tb_f(input logic [15:0] v);
        tb_f = (tb_rot(v, 1) & tb_rot(v, 8)) ^ tb_rot(v, 2);
    endfunction

    function automatic logic [15:0] tb_subkey(input logic [63:0] key, input int idx);
        logic [15:0] ks [0:31];
        logic [15:0] t;
        for (int i = 0; i < 4; i++) ks[i] = key[16*i +: 16];
        for (int i = 4; i < 32; i++) begin
            t = tb_rot(ks[i-1], 13) ^ ks[i-3];
            t = t ^ tb_rot(t, 15);
            ks[i] = ~ks[i-4] ^ t ^ {15'h0, TB_Z[61-(i-4)]} ^ 16'h0003;
        end
        tb_subkey = ks[idx];
    endfunction

    function automatic logic [63:0] tb_tail_key(input logic [63:0] key);
        tb_tail_key = {tb_subkey(key, 31), tb_subkey(key, 30),
                       tb_subkey(key, 29), tb_subkey(key, 28)};
    endfunction

    function automatic logic [31:0] tb_encrypt(input logic [63:0] key, input logic [31:0] pt);
        logic [15:0] x, y, t;
        x = pt[31:16];
        y = pt[15:0];
        for (int i = 0; i < 32; i++) begin
            t = x;
            x = y ^ tb_f(x) ^ tb_subkey(key, i);
            y = t;
        end
        tb_encrypt = {x, y};
    endfunction

    // ---------------- check helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic issue(input logic dec, input logic [31:0] blk,
                         input logic [63:0] ek, input logic [63:0] dk);
        @(negedge clk);
        req_valid   = 1'b1;
        req_decrypt = dec;
        req_block   = blk;
        enc_key     = ek;
        dec_key     = dk;
        @(negedge clk);
        req_valid   = 1'b0;
        check("R2 valid after request", {31'h0, res_valid}, 32'h1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'h0, res_valid}, 32'h0);
        check("R1 block in reset", res_block, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid after release", {31'h0, res_valid}, 32'h0);
        check("R1 block after release", res_block, 32'h0);
    endtask

    task automatic t_known_vector();
        logic [63:0] k;
        k = 64'h1918_1110_0908_0100;
        issue(1'b0, 32'h6565_6877, k, 64'h0);
        check("R3 known encryption", res_block, 32'hC69B_E9BB);
        issue(1'b1, 32'hC69B_E9BB, 64'h0, tb_tail_key(k));
        check("R4 known decryption", res_block, 32'h6565_6877);
        @(negedge clk);
        check("R2 valid drops when idle", {31'h0, res_valid}, 32'h0);
    endtask

    task automatic t_patterns();
        logic [63:0] keys [0:3];
        logic [31:0] blks [0:3];
        logic [31:0] ct;
        keys[0] = 64'h0;                    blks[0] = 32'h0;
        keys[1] = 64'hFFFF_FFFF_FFFF_FFFF;  blks[1] = 32'hFFFF_FFFF;
        keys[2] = 64'h0123_4567_89AB_CDEF;  blks[2] = 32'h8000_0001;
        keys[3] = 64'hA5A5_3C3C_0F0F_9669;  blks[3] = 32'h1234_ABCD;
        for (int i = 0; i < 4; i++) begin
            ct = tb_encrypt(keys[i], blks[i]);
            issue(1'b0, blks[i], keys[i], ~keys[i]);
            check("R5 encryption pattern", res_block, ct);
            issue(1'b1, res_block, ~keys[i], tb_tail_key(keys[i]));
            check("R6 round trip", res_block, blks[i]);
        end
    endtask

    task automatic t_unused_key();
        logic [63:0] k;
        logic [31:0] ref_ct;
        k = 64'h7E57_0BAD_C0DE_5EED;
        ref_ct = tb_encrypt(k, 32'h0F0F_F0F0);
        issue(1'b0, 32'h0F0F_F0F0, k, 64'h0);
        check("R7 enc with dec_key zero", res_block, ref_ct);
        issue(1'b0, 32'h0F0F_F0F0, k, 64'hDEAD_BEEF_CAFE_F00D);
        check("R7 enc with dec_key changed", res_block, ref_ct);
        issue(1'b1, ref_ct, 64'h0, tb_tail_key(k));
        check("R7 dec with enc_key zero", res_block, 32'h0F0F_F0F0);
        issue(1'b1, ref_ct, 64'hFFFF_0000_FFFF_0000, tb_tail_key(k));
        check("R7 dec with enc_key changed", res_block, 32'h0F0F_F0F0);
    endtask

    task automatic t_idle_hold();
        logic [31:0] held;
        issue(1'b0, 32'h2468_ACE0, 64'h1111_2222_3333_4444, 64'h0);
        held = res_block;
        for (int i = 0; i < 4; i++) begin
            req_decrypt = i[0];
            req_block   = 32'h5555_0000 + i;
            enc_key     = {16'h9999, 48'(i)};
            dec_key     = ~enc_key;
            @(negedge clk);
            check("R8 block held while idle", res_block, held);
            check("R8 valid low while idle", {31'h0, res_valid}, 32'h0);
        end
    endtask

    task automatic t_back_to_back();
        logic [63:0] ka, kb;
        logic [31:0] ca;
        ka = 64'h0F1E_2D3C_4B5A_6978;
        kb = 64'h8877_6655_4433_2211;
        ca = tb_encrypt(ka, 32'hCAFE_BABE);
        @(negedge clk);
        req_valid = 1'b1; req_decrypt = 1'b0; req_block = 32'hCAFE_BABE;
        enc_key = ka; dec_key = 64'h0;
        @(negedge clk);
        check("R9 first of burst", res_block, ca);
        req_decrypt = 1'b1; req_block = ca; enc_key = kb; dec_key = tb_tail_key(ka);
        @(negedge clk);
        check("R9 second of burst", res_block, 32'hCAFE_BABE);
        req_decrypt = 1'b0; req_block = 32'h0BAD_F00D; enc_key = kb;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 third of burst", res_block, tb_encrypt(kb, 32'h0BAD_F00D));
        check("R9 valid through burst", {31'h0, res_valid}, 32'h1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_known_vector();
        t_patterns();
        t_unused_key();
        t_idle_hold();
        t_back_to_back();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        finish_run();
    end

endmodule